// File: doc/BRIEF.md
# Eight-Bit Bidirectional Port with Output Latch

This block is a general-purpose eight-pin I/O port that sits on a small processor register bus. Software controls it through three registers: an output-data store, a per-pin direction store, and a pin register. Writes to either the pin register or the data store load the same output latch. Reads of the two differ. The data store reads back what software meant to drive. The pin register reads back the synchronised levels actually present at the pads. Because of this split, read-modify-write sequences that go through the data store are safe even when pins are inputs or loaded externally.

For each pin the block drives an output value and an output enable toward a pad cell, and it samples the pad's input level. A direction bit of 1 turns off that pin's driver. A separate mode input hands the pins to a parallel slave port and forces every driver off. Register writes still land while that mode is active, so the port can be set up before the mode is released.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset, every direction bit is 1, the output latch is 0x00, `pad_oe` is 0x00 and `pad_out` is 0x00.
- R2: A write (`wr_en`=1) to address 0 (pin register) or address 1 (data store) loads `wdata` into the output latch at the clock edge, and `pad_out` shows the latch value from then on.
- R3: A read of address 1 returns the output latch value, whatever the pad levels are.
- R4: A read of address 0 returns `pad_in` as sampled two clock edges earlier: a change at the pads is not visible after one edge and is visible after the second.
- R5: `pad_oe` bit i is 1 exactly when direction bit i is 0 and slave mode is off. For example, direction 0xCF gives `pad_oe` = 0x30.
- R6: A read of address 2 returns the direction register, and a write to address 2 loads it.
- R7: While `slave_mode` is 1, `pad_oe` is 0x00 whatever the direction bits are. Writes to the latch and direction registers still take effect, and the stored direction governs `pad_oe` again once the mode is cleared.
- R8: A read of address 3 returns 0x00, and a write to address 3 changes neither the latch nor the direction register.
- R9: While `wr_en` is 0, neither register changes, whatever the values on `addr` and `wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 pin, 1 data store, 2 direction, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| slave_mode | input | 1 | Parallel slave port mode, which forces all drivers off |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Output value to the pads |
| pad_oe | output | 8 | Per-pin output enable, 1 = drive |

## Verification
The bench drives pad levels that disagree with the latch. A design that returned pin state from the data-store read would then show the pad value instead of the stored one. It changes the pads and reads the pin register after one edge and again after the second edge, so a synchroniser that is too short or too long shows the new value at the wrong read. It writes the mixed direction pattern 0xCF to catch an inverted or bit-swapped enable. It writes registers while slave mode is set, which catches a design that blocks storage in that mode or lets drivers through. Writes to the unused address and address activity with the strobe low must leave both registers unchanged when they are read back.

// File: rtl/gpio_pkg.sv
// Shared definitions for the general-purpose port.
// Assumes a two-bit register address space.
package gpio_pkg;
    typedef enum logic [1:0] {
        SEL_PINS = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchroniser for asynchronous pad inputs.
// Assumes STAGES >= 2. The output lags the input by STAGES edges.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the pad levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Holds the output latch and the direction register.
// Assumes single-cycle writes qualified by wr_en. Address 3 is not mapped.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] dir_q
);
    reg_sel_e sel;
    logic     lat_we;
    logic     dir_we;

    // Decode which register a write targets.
    always_comb begin
        sel    = reg_sel_e'(addr);
        lat_we = wr_en && (sel == SEL_PINS || sel == SEL_DATA);
        dir_we = wr_en && (sel == SEL_DIR);
    end

    // Output latch: reset clear, loaded by pin-register or data-store writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (lat_we) lat_q <= wdata;
    end

    // Direction register: reset to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (dir_we) dir_q <= wdata;
    end
endmodule

// File: rtl/gpio_drive.sv
// Per-pin driver control toward the pad cells.
// Assumes a direction bit of 1 means input. Slave mode overrides every pin.
module gpio_drive #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic             slave_mode,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Enable pin i only when it is an output and the port is not handed over.
        always_comb begin
            pad_out[i] = lat_q[i];
            pad_oe[i]  = !dir_q[i] && !slave_mode;
        end
    end
endmodule

// File: rtl/gpio_rdmux.sv
// Combinational read-data selector.
// Assumes the address is stable while rdata is sampled.
module gpio_rdmux
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] pins_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] rdata
);
    // Pick the addressed source. The unmapped slot reads as zero.
    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_PINS: rdata = pins_q;
            SEL_DATA: rdata = lat_q;
            SEL_DIR:  rdata = dir_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
// Top level of the eight-bit bidirectional port.
// Assumes pad_in is asynchronous and that slave_mode comes from a synchronous control register.
module gpio_port #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic             slave_mode,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pins_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(pins_q)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .lat_q(lat_q), .dir_q(dir_q)
    );

    gpio_drive #(.WIDTH(WIDTH)) u_drive (
        .lat_q(lat_q), .dir_q(dir_q), .slave_mode(slave_mode),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    gpio_rdmux #(.WIDTH(WIDTH)) u_rdmux (
        .addr(addr), .pins_q(pins_q), .lat_q(lat_q), .dir_q(dir_q), .rdata(rdata)
    );
endmodule

// File: rtl/gpio_port_chk.sv
// Property checker for gpio_port, attached by bind.
// Assumes the default two-stage synchroniser.
module gpio_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [WIDTH-1:0] wdata,
    input logic [WIDTH-1:0] rdata,
    input logic             slave_mode,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe
);
    logic [1:0] cyc;
    logic       ready;

    // Count edges since reset release so that $past never reaches into reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end
    assign ready = (cyc >= 2'd2);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd0) |-> (pad_out == '0 && pad_oe == '0));
    // R2
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(wr_en) && $past(addr) <= 2'd1) |-> (pad_out == $past(wdata)));
    // R4
    pin_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && addr == 2'd0) |-> (rdata == $past(pad_in, 2)));
    // R5
    dir_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd2) |-> ((pad_oe & rdata) == '0));
    // R7
    slave_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (pad_oe == '0));
    // R8
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd3) |-> (rdata == '0));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(wr_en)) |-> $stable(pad_out));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .slave_mode(slave_mode), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       slave_mode = 1'b0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    typedef struct {
        int         kind;   // 0 rdata, 1 pad_oe, 2 pad_out
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    event  sample_ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #5 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .slave_mode(slave_mode), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Monitor: pop the expected item and compare it with the observed output.
    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                act = (it.kind == 0) ? rdata : (it.kind == 1) ? pad_oe : pad_out;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver: push one expectation and let the monitor sample it.
    task automatic expect_item(input int kind, input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        if (kind == 0) addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
        #1;
        -> sample_ev;
        #1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_item(1, 0, 8'h00, "R1 oe");
        expect_item(2, 0, 8'h00, "R1 out");
        expect_item(0, 2, 8'hFF, "R1 dir");
        expect_item(0, 1, 8'h00, "R1 latch");

        // R2 both addresses load the same latch
        reg_write(2'd1, 8'h5A);
        expect_item(0, 1, 8'h5A, "R2 data-store write");
        expect_item(2, 0, 8'h5A, "R2 pad_out");
        reg_write(2'd0, 8'hA5);
        expect_item(0, 1, 8'hA5, "R2 pin-register write");
        expect_item(2, 0, 8'hA5, "R2 pad_out after pin write");

        // R3 latch read ignores the pads, R4 pin read follows them
        pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        expect_item(0, 1, 8'hA5, "R3 latch vs pads");
        expect_item(0, 0, 8'h3C, "R4 pin read");

        // R4 two-edge latency
        @(negedge clk);
        pad_in = 8'hC3;
        @(negedge clk);
        expect_item(0, 0, 8'h3C, "R4 after one edge");
        @(negedge clk);
        expect_item(0, 0, 8'hC3, "R4 after two edges");

        // R5 and R6 direction
        reg_write(2'd2, 8'hCF);
        expect_item(1, 0, 8'h30, "R5 oe for CF");
        expect_item(0, 2, 8'hCF, "R6 dir readback");
        reg_write(2'd2, 8'h00);
        expect_item(1, 0, 8'hFF, "R5 all outputs");

        // R7 slave mode
        @(negedge clk);
        slave_mode = 1'b1;
        expect_item(1, 0, 8'h00, "R7 oe forced off");
        reg_write(2'd1, 8'h11);
        reg_write(2'd2, 8'hF0);
        expect_item(1, 0, 8'h00, "R7 oe still off");
        expect_item(0, 1, 8'h11, "R7 latch written in mode");
        expect_item(0, 2, 8'hF0, "R7 dir written in mode");
        @(negedge clk);
        slave_mode = 1'b0;
        expect_item(1, 0, 8'h0F, "R7 oe after mode clear");

        // R8 unused address
        expect_item(0, 3, 8'h00, "R8 read of hole");
        reg_write(2'd3, 8'hFF);
        expect_item(0, 1, 8'h11, "R8 latch unchanged");
        expect_item(0, 2, 8'hF0, "R8 dir unchanged");

        // R9 no strobe, no change
        @(negedge clk);
        addr = 2'd1; wdata = 8'hEE;
        @(negedge clk);
        addr = 2'd2; wdata = 8'h0E;
        @(negedge clk);
        expect_item(0, 1, 8'h11, "R9 latch held");
        expect_item(0, 2, 8'hF0, "R9 dir held");

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_item(0, 2, 8'hFF, "R1 dir after reset");
        expect_item(2, 0, 8'h00, "R1 out after reset");
        expect_item(1, 0, 8'h00, "R1 oe after reset");

        @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule